// File: doc/BRIEF.md
# SD Host Control Register

This block is the 32-bit host control register of an SD/MMC host controller. Software writes it through a simple write port and reads it back at any time. The stored fields drive the controller's card bus power, card voltage, data bus width, output clock-edge choice, DMA mode, card-detect source, wakeup enables and block-gap handling.

Some fields are not plain storage, because live status from the controller shapes them. Power is refused when the requested voltage is not supported, and it drops when no card is present. The continue request clears itself once the data line becomes busy. The DMA mode and the out-of-band wakeup enable are only writable while their feature enables are set. Reserved positions always read as zero.

Top module: `sdhc_host_ctrl_reg`

## Requirements
- R1: After reset every field is zero: `rd_data` reads 0x00000000 and every control output is 0.
- R2: Bits 31:28, 23:20, 15:12, bit 5 and bit 0 always read zero, and writing ones to them changes nothing.
- R3: Bit 27 (out-of-band wakeup enable, output `wake_oob`) takes a written value only while `oob_irq_en` is 1. Otherwise it keeps its stored value.
- R4: Whenever `card_present` is 0 at a clock edge, bus power (bit 8, `bus_power`) becomes 0, whether or not a write sets it in the same cycle.
- R5: A write of 1 to bit 8 sets power only when the voltage code written to bits 11:9 in the same write is supported: code 7 with `cap_3v3`, code 6 with `cap_3v0`, code 5 with `cap_1v8`. Any other code is never supported. An unsupported request leaves power unchanged. A write of 0 to bit 8 always clears power.
- R6: The DMA select field (bits 4:3, `dma_sel`) stores a write only while `mdma_en` is 1. While `mdma_en` is 0 it reads 0 and drives 0, but it keeps the stored code. Every code, including the reserved 0, 1 and 3, is stored as written (2 is 32-bit ADMA2).
- R7: The continue request (bit 17, `cont_req`) becomes 0 after any edge where `dat_active` or `wr_xfer_active` is 1. This clear overrides a write of 1 in the same cycle.
- R8: The plain fields store the written value and drive their outputs: wakeup enables on removal, insertion and card interrupt (bits 26, 25, 24); interrupt at gap (19); read wait (18); stop at gap (16); voltage (11:9); card-detect source (7); card-detect test level (6); high-speed enable (2, where 1 means output data changes on the rising SD clock edge and 0 means the falling edge); 4-bit width (1).
- R9: A write takes effect at the clock edge on which `wr_en` is 1. `rd_data` shows the new value right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| card_present | input | 1 | Controller sees a card |
| dat_active | input | 1 | DAT line busy |
| wr_xfer_active | input | 1 | Write transfer in progress |
| cap_3v3 | input | 1 | 3.3 V supported |
| cap_3v0 | input | 1 | 3.0 V supported |
| cap_1v8 | input | 1 | 1.8 V supported |
| mdma_en | input | 1 | Multi-mode DMA enable |
| oob_irq_en | input | 1 | Out-of-band interrupt enable |
| bus_power | output | 1 | Card bus power on |
| bus_volt | output | 3 | Selected voltage code |
| width_4bit | output | 1 | 4-bit data width |
| hs_rising | output | 1 | Drive outputs on rising SD clock edge |
| dma_sel | output | 2 | DMA mode code |
| cd_sel_test | output | 1 | Card detect from test level |
| cd_test_lvl | output | 1 | Card-detect test level |
| wake_oob | output | 1 | Wakeup on out-of-band interrupt |
| wake_remove | output | 1 | Wakeup on card removal |
| wake_insert | output | 1 | Wakeup on card insertion |
| wake_card_irq | output | 1 | Wakeup on card interrupt |
| irq_at_gap | output | 1 | Interrupt detect at block gap |
| read_wait_en | output | 1 | Read wait enable |
| cont_req | output | 1 | Continue request |
| stop_at_gap | output | 1 | Stop at block gap request |

## Verification
A table of writes is applied, each paired with a status pattern, and the readback is compared after every write. The patterns separate the following cases: an all-ones write (which exposes reserved and gated bits), power requests whose voltage is supported against ones whose voltage is not, power requests made while the card is absent, and the continue request raised while the data line or a write transfer is busy and while both are idle. Directed tests then cover reset, the removal of the DMA enable without a write, and the loss of the card without a write. These show whether a field is stored but masked, or was never stored at all.

// File: rtl/sdhc_hctl_pkg.sv
package sdhc_hctl_pkg;

    localparam int REG_W  = 32;
    localparam int VOLT_W = 3;
    localparam int DMA_W  = 2;

    localparam logic [VOLT_W-1:0] VCODE_3V3 = 3'd7;
    localparam logic [VOLT_W-1:0] VCODE_3V0 = 3'd6;
    localparam logic [VOLT_W-1:0] VCODE_1V8 = 3'd5;

    // bit positions that software decodes
    localparam int B_WAKE_OOB = 27;
    localparam int B_WAKE_REM = 26;
    localparam int B_WAKE_INS = 25;
    localparam int B_WAKE_CRD = 24;
    localparam int B_IRQ_GAP  = 19;
    localparam int B_RD_WAIT  = 18;
    localparam int B_CONT     = 17;
    localparam int B_STOP     = 16;
    localparam int B_VOLT_LO  = 9;
    localparam int B_PWR      = 8;
    localparam int B_CD_SEL   = 7;
    localparam int B_CD_LVL   = 6;
    localparam int B_DMA_LO   = 3;
    localparam int B_HS       = 2;
    localparam int B_W4       = 1;

    localparam logic [REG_W-1:0] RSVD_MASK = 32'hF0F0_F021;

    typedef struct packed {
        logic              wake_oob;
        logic              wake_rem;
        logic              wake_ins;
        logic              wake_crd;
        logic              irq_gap;
        logic              rd_wait;
        logic              cont;
        logic              stop;
        logic [VOLT_W-1:0] volt;
        logic              pwr;
        logic              cd_sel;
        logic              cd_lvl;
        logic [DMA_W-1:0]  dma;
        logic              hs;
        logic              w4;
    } hctl_regs_t;

endpackage

// File: rtl/sdhc_hctl_volt_qual.sv
module sdhc_hctl_volt_qual
    import sdhc_hctl_pkg::*;
(
    input  logic [VOLT_W-1:0] volt_code,
    input  logic              cap_3v3,
    input  logic              cap_3v0,
    input  logic              cap_1v8,
    output logic              volt_ok
);
    always_comb begin
        unique case (volt_code)
            VCODE_3V3: volt_ok = cap_3v3;
            VCODE_3V0: volt_ok = cap_3v0;
            VCODE_1V8: volt_ok = cap_1v8;
            default:   volt_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdhc_hctl_pack.sv
module sdhc_hctl_pack
    import sdhc_hctl_pkg::*;
(
    input  hctl_regs_t       regs_q,
    input  logic             mdma_en,
    output logic [REG_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        rd_data[B_WAKE_OOB] = regs_q.wake_oob;
        rd_data[B_WAKE_REM] = regs_q.wake_rem;
        rd_data[B_WAKE_INS] = regs_q.wake_ins;
        rd_data[B_WAKE_CRD] = regs_q.wake_crd;
        rd_data[B_IRQ_GAP]  = regs_q.irq_gap;
        rd_data[B_RD_WAIT]  = regs_q.rd_wait;
        rd_data[B_CONT]     = regs_q.cont;
        rd_data[B_STOP]     = regs_q.stop;
        rd_data[B_VOLT_LO +: VOLT_W] = regs_q.volt;
        rd_data[B_PWR]      = regs_q.pwr;
        rd_data[B_CD_SEL]   = regs_q.cd_sel;
        rd_data[B_CD_LVL]   = regs_q.cd_lvl;
        rd_data[B_DMA_LO +: DMA_W] = mdma_en ? regs_q.dma : '0;
        rd_data[B_HS]       = regs_q.hs;
        rd_data[B_W4]       = regs_q.w4;
    end
endmodule

// File: rtl/sdhc_host_ctrl_reg.sv
module sdhc_host_ctrl_reg
    import sdhc_hctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              card_present,
    input  logic              dat_active,
    input  logic              wr_xfer_active,
    input  logic              cap_3v3,
    input  logic              cap_3v0,
    input  logic              cap_1v8,
    input  logic              mdma_en,
    input  logic              oob_irq_en,
    output logic              bus_power,
    output logic [VOLT_W-1:0] bus_volt,
    output logic              width_4bit,
    output logic              hs_rising,
    output logic [DMA_W-1:0]  dma_sel,
    output logic              cd_sel_test,
    output logic              cd_test_lvl,
    output logic              wake_oob,
    output logic              wake_remove,
    output logic              wake_insert,
    output logic              wake_card_irq,
    output logic              irq_at_gap,
    output logic              read_wait_en,
    output logic              cont_req,
    output logic              stop_at_gap
);
    hctl_regs_t regs_d, regs_q;
    logic       wr_volt_ok;

    sdhc_hctl_volt_qual u_volt_qual (
        .volt_code (wr_data[B_VOLT_LO +: VOLT_W]),
        .cap_3v3   (cap_3v3),
        .cap_3v0   (cap_3v0),
        .cap_1v8   (cap_1v8),
        .volt_ok   (wr_volt_ok)
    );

    sdhc_hctl_pack u_pack (
        .regs_q  (regs_q),
        .mdma_en (mdma_en),
        .rd_data (rd_data)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (oob_irq_en) regs_d.wake_oob = wr_data[B_WAKE_OOB];
            regs_d.wake_rem = wr_data[B_WAKE_REM];
            regs_d.wake_ins = wr_data[B_WAKE_INS];
            regs_d.wake_crd = wr_data[B_WAKE_CRD];
            regs_d.irq_gap  = wr_data[B_IRQ_GAP];
            regs_d.rd_wait  = wr_data[B_RD_WAIT];
            regs_d.cont     = wr_data[B_CONT];
            regs_d.stop     = wr_data[B_STOP];
            regs_d.volt     = wr_data[B_VOLT_LO +: VOLT_W];
            if (!wr_data[B_PWR])  regs_d.pwr = 1'b0;
            else if (wr_volt_ok)  regs_d.pwr = 1'b1;
            regs_d.cd_sel   = wr_data[B_CD_SEL];
            regs_d.cd_lvl   = wr_data[B_CD_LVL];
            if (mdma_en) regs_d.dma = wr_data[B_DMA_LO +: DMA_W];
            regs_d.hs       = wr_data[B_HS];
            regs_d.w4       = wr_data[B_W4];
        end
        // hardware clears take priority over software writes
        if (dat_active || wr_xfer_active) regs_d.cont = 1'b0;
        if (!card_present)                regs_d.pwr  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_power     = regs_q.pwr;
    assign bus_volt      = regs_q.volt;
    assign width_4bit    = regs_q.w4;
    assign hs_rising     = regs_q.hs;
    assign dma_sel       = mdma_en ? regs_q.dma : '0;
    assign cd_sel_test   = regs_q.cd_sel;
    assign cd_test_lvl   = regs_q.cd_lvl;
    assign wake_oob      = regs_q.wake_oob;
    assign wake_remove   = regs_q.wake_rem;
    assign wake_insert   = regs_q.wake_ins;
    assign wake_card_irq = regs_q.wake_crd;
    assign irq_at_gap    = regs_q.irq_gap;
    assign read_wait_en  = regs_q.rd_wait;
    assign cont_req      = regs_q.cont;
    assign stop_at_gap   = regs_q.stop;

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & RSVD_MASK) == '0);

    assert_oob_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !oob_irq_en |=> $stable(wake_oob));

    assert_nocard_pwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !card_present |=> !bus_power);

    assert_pwr_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_power) |-> $past(wr_en && wr_data[B_PWR] && wr_volt_ok));

    assert_dma_rd_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_DMA_LO +: DMA_W] == dma_sel);

    assert_cont_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_active || wr_xfer_active) |=> !cont_req);

endmodule

// File: tb/sdhc_host_ctrl_reg_bench.sv
module sdhc_host_ctrl_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        card_present = 1'b0, dat_active = 1'b0, wr_xfer_active = 1'b0;
    logic        cap_3v3 = 1'b0, cap_3v0 = 1'b0, cap_1v8 = 1'b0;
    logic        mdma_en = 1'b0, oob_irq_en = 1'b0;
    logic        bus_power, width_4bit, hs_rising, cd_sel_test, cd_test_lvl;
    logic [2:0]  bus_volt;
    logic [1:0]  dma_sel;
    logic        wake_oob, wake_remove, wake_insert, wake_card_irq;
    logic        irq_at_gap, read_wait_en, cont_req, stop_at_gap;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sdhc_host_ctrl_reg u_sdhc_host_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .card_present(card_present),
        .dat_active(dat_active), .wr_xfer_active(wr_xfer_active),
        .cap_3v3(cap_3v3), .cap_3v0(cap_3v0), .cap_1v8(cap_1v8),
        .mdma_en(mdma_en), .oob_irq_en(oob_irq_en),
        .bus_power(bus_power), .bus_volt(bus_volt), .width_4bit(width_4bit),
        .hs_rising(hs_rising), .dma_sel(dma_sel), .cd_sel_test(cd_sel_test),
        .cd_test_lvl(cd_test_lvl), .wake_oob(wake_oob),
        .wake_remove(wake_remove), .wake_insert(wake_insert),
        .wake_card_irq(wake_card_irq), .irq_at_gap(irq_at_gap),
        .read_wait_en(read_wait_en), .cont_req(cont_req),
        .stop_at_gap(stop_at_gap)
    );

    // status byte: [7] card [6] dat [5] wrx [4] 3v3 [3] 3v0 [2] 1v8 [1] mdma [0] oob
    localparam int NV = 13;
    localparam logic [71:0] VEC [NV] = '{
        {32'hFFFF_FFFF, 8'b1001_1110, 32'h070F_0FDE}, // R2 R3 R8: all ones
        {32'h0800_0000, 8'b1001_1111, 32'h0800_0000}, // R3 oob enabled
        {32'h0000_0B00, 8'b1001_1001, 32'h0000_0A00}, // R5 1.8V unsupported
        {32'h0000_0B00, 8'b1001_1101, 32'h0000_0B00}, // R5 1.8V supported
        {32'h0000_0D10, 8'b1000_1000, 32'h0000_0D00}, // R6 dma blocked
        {32'h0000_0D10, 8'b1000_1010, 32'h0000_0D10}, // R6 dma code 2
        {32'h0002_0D10, 8'b1100_1010, 32'h0000_0D10}, // R7 dat active wins
        {32'h0002_0D10, 8'b1010_1010, 32'h0000_0D10}, // R7 write xfer wins
        {32'h0002_0D10, 8'b1000_1010, 32'h0002_0D10}, // R7 idle stores
        {32'h0002_0D10, 8'b0000_1010, 32'h0002_0C10}, // R4 no card wins
        {32'h0000_0E00, 8'b1000_1010, 32'h0000_0E00}, // R5 write 0 clears
        {32'h0000_0F00, 8'b1001_0010, 32'h0000_0F00}, // R5 3.3V supported
        {32'h0000_0718, 8'b1001_1110, 32'h0000_0718}  // R5 code 3 keeps, R6 code 3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_status(input logic [7:0] s);
        {card_present, dat_active, wr_xfer_active, cap_3v3, cap_3v0, cap_1v8,
         mdma_en, oob_irq_en} = s;
    endtask

    // drive at negedge, one rising edge, sample at the following negedge
    task automatic step(input logic we, input logic [31:0] wd, input logic [7:0] s);
        set_status(s);
        wr_en = we;
        wr_data = wd;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset rd", rd_data, 32'h0);
        check("R1 reset outputs",
              {15'd0, bus_power, bus_volt, width_4bit, hs_rising, dma_sel,
               cd_sel_test, cd_test_lvl, wake_oob, wake_remove, wake_insert,
               wake_card_irq, irq_at_gap, read_wait_en, cont_req, stop_at_gap}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][71:40], VEC[i][39:32]);
            check($sformatf("R9 vector %0d", i), rd_data, VEC[i][31:0]);
            if (i == 0) begin
                check("R8 outputs after all ones",
                      {hs_rising, width_4bit, cd_sel_test, cd_test_lvl, wake_remove,
                       wake_insert, wake_card_irq, irq_at_gap, read_wait_en,
                       stop_at_gap, bus_volt},
                      {10'b11_1111_1111, 3'd7});
                check("R3 wake_oob blocked", {31'd0, wake_oob}, 32'd0);
            end
            if (i == 5) check("R6 dma_sel port", {30'd0, dma_sel}, 32'd2);
            if (i == 8) check("R7 cont_req port", {31'd0, cont_req}, 32'd1);
        end

        // R6: store kept while masked
        step(1'b1, 32'h0000_0F10, 8'b1001_1110);
        step(1'b0, 32'h0, 8'b1001_1100);
        check("R6 masked rd", rd_data, 32'h0000_0F00);
        check("R6 masked port", {30'd0, dma_sel}, 32'd0);
        step(1'b0, 32'h0, 8'b1001_1110);
        check("R6 unmasked rd", rd_data, 32'h0000_0F10);

        // R4: card lost with no write
        step(1'b0, 32'h0, 8'b0001_1110);
        check("R4 no write power drop", {31'd0, bus_power}, 32'd0);
        check("R4 rd after drop", rd_data, 32'h0000_0E10);

        // R7: cont request cleared later with no write
        step(1'b1, 32'h0002_0000, 8'b1001_1110);
        check("R7 cont set", {31'd0, cont_req}, 32'd1);
        step(1'b0, 32'h0, 8'b1101_1110);
        check("R7 cont cleared by dat", {31'd0, cont_req}, 32'd0);

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 second reset", rd_data, 32'h0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule